// File: doc/BRIEF.md
# Relocatable Exception Vector Fetcher

This block reads entries of an exception vector table from memory. The table starts at a programmable base address. After reset the block runs a boot sequence on its own. First it reads the word at the table start and hands it out as the initial main stack pointer. It then reads the next word and hands it out as the reset handler address. After that, a one-cycle command carrying an exception number makes it read that exception's handler address from the table.

Memory is reached through a simple word-read port. The block raises a request with an address and holds both until the memory acknowledges. The data word arrives in the same cycle as the acknowledge. Every handler address carries an instruction-state flag in bit 0, which must be 1. The block strips that bit before presenting the new program counter. If a fetched entry has the flag clear, the block raises a fault strobe instead of a valid program counter. Stacking of registers, priority arbitration and the memory itself sit outside this block.

Top module: `vector_fetcher`

## Requirements
- R1: After reset the table base is 0, `busy` and `memReq` are high, and the first read is at address 0x00000000.
- R2: When the read of table word 0 is acknowledged, `spValid` pulses high for exactly the following cycle. In that cycle `spValue` holds the fetched word with bits 1:0 cleared.
- R3: Once the stack pointer read is acknowledged, the next read is at base + 4, the reset handler entry. Its result appears on the program-counter outputs.
- R4: A `fetchReq` accepted while idle starts a read at base + 4 × `excNum`.
- R5: When a handler read is acknowledged with bit 0 = 1, `pcValid` pulses high for exactly the following cycle. In that cycle `pcValue` equals the fetched word with bit 0 cleared.
- R6: When a handler read is acknowledged with bit 0 = 0, `stateFault` pulses high for the following cycle and `pcValid` stays low.
- R7: A base write with `baseWrEn` sets the base to `baseWrData` with bits 6:0 forced to zero, so the table is always 128-byte aligned.
- R8: While `memReq` is high and `memAck` is low, `memReq` stays high in the next cycle and `memAddr` does not change.
- R9: `busy` is high from reset until the reset handler read completes, and during every exception fetch. A `fetchReq` seen while `busy` is high is dropped: it starts no read, neither then nor later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Write strobe for the table base register |
| baseWrData | input | ADDR_W | New table base (bits 6:0 ignored) |
| fetchReq | input | 1 | Start a handler fetch for `excNum` |
| excNum | input | VEC_NUM_W | Exception number to fetch |
| busy | output | 1 | A fetch is in progress |
| memReq | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memAck | input | 1 | Memory acknowledge; `memData` valid |
| memData | input | ADDR_W | Memory read data |
| spValid | output | 1 | One-cycle strobe: new stack pointer ready |
| spValue | output | ADDR_W | Initial main stack pointer, word aligned |
| pcValid | output | 1 | One-cycle strobe: new program counter ready |
| pcValue | output | ADDR_W | Handler address with bit 0 cleared |
| stateFault | output | 1 | One-cycle strobe: fetched handler had bit 0 clear |

## Verification
The handler fetch is tried against a table of base values and exception numbers. Some bases are already aligned and some carry stray low bits. The exception numbers include 0, 1 and the highest number. Together these show whether the address is built from the masked base plus a scaled index, and not from the raw written value. The fetched words include entries with bit 0 set and with bit 0 clear, which separates the program-counter path from the fault path. Acknowledge delays of zero and several cycles show that the request and address are held. Commands issued during the boot sequence and during an exception fetch show that busy commands are dropped and not queued.

// File: rtl/vf_pkg.sv
package vf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RST_SP = 2'd1,
    ST_RST_PC = 2'd2,
    ST_EXC    = 2'd3
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRstPc;  // load address of reset handler entry
    logic loadExc;    // load address of exception entry
    logic captureSp;  // capture read data as stack pointer
    logic capturePc;  // capture read data as handler address
  } dpStrobe_t;

endpackage

// File: rtl/vf_control.sv
module vf_control
  import vf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       memAck,
  output dpStrobe_t  strobe,
  output logic       memReq
);

  fetchState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RST_SP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (fetchReq) begin
          strobe.loadExc = 1'b1;
          stateNext      = ST_EXC;
        end
      end
      ST_RST_SP: begin
        if (memAck) begin
          strobe.captureSp = 1'b1;
          strobe.loadRstPc = 1'b1;
          stateNext        = ST_RST_PC;
        end
      end
      ST_RST_PC, ST_EXC: begin
        if (memAck) begin
          strobe.capturePc = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReq = (state != ST_IDLE);

endmodule

// File: rtl/vf_datapath.sv
module vf_datapath
  import vf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_NUM_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 baseWrEn,
  input  logic [ADDR_W-1:0]    baseWrData,
  input  logic [VEC_NUM_W-1:0] excNum,
  input  logic [ADDR_W-1:0]    memData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 spValid,
  output logic [ADDR_W-1:0]    spValue,
  output logic                 pcValid,
  output logic [ADDR_W-1:0]    pcValue,
  output logic                 stateFault
);

  // table spans 2**VEC_NUM_W words, so the base aligns to that many bytes * 4
  localparam int ALIGN_LSB = VEC_NUM_W + 2;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = (ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] WORD_MASK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] LSB_MASK   = ADDR_W'(1);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] excOffset;

  assign excOffset = {{(ADDR_W-ALIGN_LSB){1'b0}}, excNum, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= '0;
    else if (baseWrEn) baseReg <= baseWrData & ~ALIGN_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) memAddr <= '0;
    else if (strobe.loadRstPc) memAddr <= baseReg + ADDR_W'(4);
    else if (strobe.loadExc)   memAddr <= baseReg + excOffset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spValid    <= 1'b0;
      spValue    <= '0;
      pcValid    <= 1'b0;
      pcValue    <= '0;
      stateFault <= 1'b0;
    end else begin
      spValid    <= strobe.captureSp;
      pcValid    <= strobe.capturePc & memData[0];
      stateFault <= strobe.capturePc & ~memData[0];
      if (strobe.captureSp) spValue <= memData & ~WORD_MASK;
      if (strobe.capturePc) pcValue <= memData & ~LSB_MASK;
    end
  end

endmodule

// File: rtl/vector_fetcher.sv
module vector_fetcher
  import vf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_NUM_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baseWrEn,
  input  logic [ADDR_W-1:0]    baseWrData,
  input  logic                 fetchReq,
  input  logic [VEC_NUM_W-1:0] excNum,
  output logic                 busy,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memAck,
  input  logic [ADDR_W-1:0]    memData,
  output logic                 spValid,
  output logic [ADDR_W-1:0]    spValue,
  output logic                 pcValid,
  output logic [ADDR_W-1:0]    pcValue,
  output logic                 stateFault
);

  dpStrobe_t strobe;

  vf_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .fetchReq (fetchReq),
    .memAck   (memAck),
    .strobe   (strobe),
    .memReq   (memReq)
  );

  vf_datapath #(
    .ADDR_W    (ADDR_W),
    .VEC_NUM_W (VEC_NUM_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .excNum     (excNum),
    .memData    (memData),
    .memAddr    (memAddr),
    .spValid    (spValid),
    .spValue    (spValue),
    .pcValid    (pcValid),
    .pcValue    (pcValue),
    .stateFault (stateFault)
  );

  assign busy = memReq;

endmodule

// File: rtl/vf_checker.sv
module vf_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              spValid,
  input logic [ADDR_W-1:0] spValue,
  input logic              pcValid,
  input logic [ADDR_W-1:0] pcValue,
  input logic              stateFault
);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_word_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));

  assert_sp_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    spValid |-> (spValue[1:0] == 2'b00));

  assert_pc_lsb_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |-> (pcValue[0] == 1'b0));

  assert_fault_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(pcValid && stateFault));

  assert_pc_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |=> !pcValid);

  assert_sp_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    spValid |=> !spValid);

endmodule

bind vector_fetcher vf_checker #(.ADDR_W(ADDR_W)) i_vf_checker (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memAck     (memAck),
  .memAddr    (memAddr),
  .spValid    (spValid),
  .spValue    (spValue),
  .pcValid    (pcValid),
  .pcValue    (pcValue),
  .stateFault (stateFault)
);

// File: tb/test_vector_fetcher.sv
module test_vector_fetcher;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NW = 5;
  localparam int NVEC = 5;

  // stimulus: written base, exception number, fetched word, ack delay
  // expected: read address, pc value, fault
  localparam logic [31:0] tBase [NVEC] = '{32'h0000_0000, 32'h0000_1FFF, 32'h2000_0080, 32'hFFFF_FFFF, 32'h0000_4055};
  localparam logic [4:0]  tNum  [NVEC] = '{5'd3, 5'd5, 5'd31, 5'd1, 5'd0};
  localparam logic [31:0] tData [NVEC] = '{32'h0000_0201, 32'h8000_0003, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0011};
  localparam int          tWait [NVEC] = '{0, 3, 1, 5, 0};
  localparam logic [31:0] tAddr [NVEC] = '{32'h0000_000C, 32'h0000_1F94, 32'h2000_00FC, 32'hFFFF_FF84, 32'h0000_4000};
  localparam logic [31:0] tPc   [NVEC] = '{32'h0000_0200, 32'h8000_0002, 32'h1234_5678, 32'hFFFF_FFFE, 32'h0000_0010};
  localparam logic        tFlt  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          baseWrEn = 1'b0;
  logic [AW-1:0] baseWrData = '0;
  logic          fetchReq = 1'b0;
  logic [NW-1:0] excNum = '0;
  logic          busy, memReq;
  logic [AW-1:0] memAddr;
  logic          memAck = 1'b0;
  logic [AW-1:0] memData = '0;
  logic          spValid, pcValid, stateFault;
  logic [AW-1:0] spValue, pcValue;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vector_fetcher #(.ADDR_W(AW), .VEC_NUM_W(NW)) i_vector_fetcher (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .fetchReq(fetchReq), .excNum(excNum), .busy(busy), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .spValid(spValid), .spValue(spValue), .pcValid(pcValid),
    .pcValue(pcValue), .stateFault(stateFault)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: waits, checks held request/address, acknowledges
  task automatic serve(input logic [31:0] data, input logic [31:0] expAddr, input int waitCycles, input string tag);
    for (int i = 0; i < waitCycles; i++) begin
      @(negedge clk);
      check(memReq && memAddr == expAddr, "R8 request held", memAddr, expAddr);
    end
    check(memReq == 1'b1, {tag, " memReq"}, 32'(memReq), 32'd1);
    check(memAddr == expAddr, {tag, " address"}, memAddr, expAddr);
    memAck = 1'b1;
    memData = data;
    @(negedge clk);
    memAck = 1'b0;
    memData = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy && memReq, "R1 busy in reset", 32'(busy), 32'd1);
    check(memAddr == 32'h0, "R1 first address", memAddr, 32'h0);
    check(!spValid && !pcValid && !stateFault, "R1 strobes low", 32'(spValid), 32'd0);
    rstN = 1'b1;

    // R9: command during boot sequence is dropped
    fetchReq = 1'b1; excNum = 5'd7;
    serve(32'h2000_0403, 32'h0, 2, "R1 boot sp");
    fetchReq = 1'b0;
    check(spValid == 1'b1, "R2 spValid pulse", 32'(spValid), 32'd1);
    check(spValue == 32'h2000_0400, "R2 spValue", spValue, 32'h2000_0400);
    serve(32'h0000_0101, 32'h4, 1, "R3 boot pc");
    check(spValid == 1'b0, "R2 spValid single", 32'(spValid), 32'd0);
    check(pcValid && pcValue == 32'h0000_0100, "R3 reset handler", pcValue, 32'h100);
    check(!busy && !memReq, "R9 idle after boot", 32'(busy), 32'd0);
    @(negedge clk);
    check(!pcValid && !memReq, "R9 dropped boot command", 32'(memReq), 32'd0);

    // table walk: R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      baseWrEn = 1'b1; baseWrData = tBase[k];
      @(negedge clk);
      baseWrEn = 1'b0;
      fetchReq = 1'b1; excNum = tNum[k];
      @(negedge clk);
      fetchReq = 1'b0;
      check(busy == 1'b1, "R9 busy during fetch", 32'(busy), 32'd1);
      serve(tData[k], tAddr[k], tWait[k], "R4 R7 vector");
      check(pcValid == !tFlt[k], "R5 pcValid", 32'(pcValid), 32'(!tFlt[k]));
      check(stateFault == tFlt[k], "R6 stateFault", 32'(stateFault), 32'(tFlt[k]));
      if (!tFlt[k]) check(pcValue == tPc[k], "R5 pcValue", pcValue, tPc[k]);
      @(negedge clk);
      check(!pcValid && !stateFault, "R5 R6 single pulse", 32'(pcValid | stateFault), 32'd0);
    end

    // R9: command while exception fetch busy
    baseWrEn = 1'b1; baseWrData = 32'h0000_0000;
    @(negedge clk);
    baseWrEn = 1'b0;
    fetchReq = 1'b1; excNum = 5'd2;
    @(negedge clk);
    excNum = 5'd9;
    @(negedge clk);
    fetchReq = 1'b0; excNum = '0;
    serve(32'h0000_0301, 32'h8, 2, "R9 busy command");
    check(pcValid && pcValue == 32'h300, "R9 first fetch result", pcValue, 32'h300);
    check(!memReq && !busy, "R9 no queued fetch", 32'(memReq), 32'd0);
    @(negedge clk);
    check(!memReq, "R9 still idle", 32'(memReq), 32'd0);

    // R2/R1: reset again restarts boot at base 0
    baseWrEn = 1'b1; baseWrData = 32'h0000_8000;
    @(negedge clk);
    baseWrEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    serve(32'h1000_0007, 32'h0, 0, "R1 base reset");
    check(spValid && spValue == 32'h1000_0004, "R2 second boot sp", spValue, 32'h1000_0004);
    serve(32'h0000_0040, 32'h4, 0, "R3 second boot pc");
    check(stateFault && !pcValid, "R6 boot fault", 32'(stateFault), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule